// File: doc/BRIEF.md
# Reciprocal Frequency Counter with Gate Capture

This block measures the rate of an asynchronous input signal by the reciprocal method. The input is first brought into the reference clock domain, and its rising edges are counted by a prescaler whose ratio is a power of two. Each time the prescaler completes its count, it forms a divided edge. That edge captures a free-running timer clocked by the reference clock. The difference between two successive captures is the number of reference ticks spanned by exactly 2^N input cycles. The block reports both numbers, and the consumer divides them to obtain a frequency.

Consecutive gates share their boundary edge. The timer is never stopped, and the prescaler restarts on the same input edge that closes a gate. As a result, no input cycle and no reference tick falls between two results, and short gates can be summed into long ones for more resolution. The ratio can be given directly when the measurement is enabled. Otherwise an auto-range phase starts at ratio 1 and doubles it until one gate spans more than a programmable number of ticks. The timer can instead be set to restart at every capture, in which case the captured value is the interval itself.

Top module: `recip_freq_counter`

## Requirements
- R1: After reset, `res_valid`, `overrun`, `res_cycles` and `res_ticks` are all 0.
- R2: In manual mode (`auto_mode`=0 when `en` rises), the division shift is `div_sel`, clamped to MAX_SHIFT. Every result reports `res_cycles` = 2^shift, which is a single set bit.
- R3: `res_ticks` equals the number of reference clock cycles between the divided edge that closes a gate and the one before it. The first divided edge after `en` rises only arms the block and produces no result.
- R4: Gates follow each other with no gap. The sum of `res_ticks` over consecutive results equals the reference cycles spanned by the total of their input cycles, even when input periods vary.
- R5: The tick count is taken modulo 2^CNT_W, so results stay correct when the timer wraps between two captures.
- R6: When `clr_mode`=1 at the rising edge of `en`, the timer restarts at every capture. The reported ticks are the same as in free-running mode.
- R7: In auto mode (`auto_mode`=1 when `en` rises), the shift starts at 0. After the arming edge, each divided edge whose tick count is less than or equal to `min_ticks` raises the shift by one. The first divided edge above `min_ticks` fixes the shift and starts the first reported gate. No result is reported while ranging.
- R8: Auto-ranging stops raising the shift at MAX_SHIFT, even if the tick count is still less than or equal to `min_ticks`.
- R9: `res_valid` is a one-cycle pulse per completed gate.
- R10: `overrun` rises together with a `res_valid` pulse when the previous result was not acknowledged by `res_ack`. A `res_ack` pulse clears `overrun` on the next cycle.
- R11: While `en` stays high, changes on `div_sel`, `auto_mode` and `clr_mode` have no effect on the results.
- R12: While `en` is low, no result is produced. Raising `en` again restarts arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous signal to be measured |
| en | input | 1 | Measurement enable; its rising edge latches the mode inputs |
| auto_mode | input | 1 | 1 selects auto-ranging, 0 selects the manual shift |
| div_sel | input | SH_W | Manual division shift N (ratio 2^N) |
| clr_mode | input | 1 | 1 restarts the timer at every capture |
| min_ticks | input | CNT_W | Auto-range threshold in reference ticks |
| res_ack | input | 1 | Acknowledges the current result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_cycles | output | CNT_W | Input cycles in the last gate (2^N) |
| res_ticks | output | CNT_W | Reference ticks in the last gate |
| overrun | output | 1 | A result was replaced before it was acknowledged |

## Verification
Some properties are checked on every cycle:
- the strobe lasts a single cycle;
- every reported cycle count is one set bit;
- tick counts are never zero;
- the overrun flag only rises with a new result and falls after an acknowledge;
- no result appears while the block is disabled.

Other behaviour only the directed scenarios can show, since it needs an input pattern with a known timing:
- exact tick values for known input periods;
- the shift chosen by auto-ranging and its clamp;
- gap-free sums across alternating periods;
- correct counts across a timer wrap;
- the equality of clear-on-capture and free-running results.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RANGE = 2'd1,
        ST_MEAS  = 2'd2
    } rcc_state_e;
endpackage

// File: rtl/rcc_sync_edge.sv
// Brings an asynchronous level into the clock domain and flags its rising edges.
module rcc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sr_q, sr_d;

    always_comb begin
        sr_d = {sr_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/rcc_prescaler.sv
// Counts synchronized edges and emits a gate pulse on every 2^shift-th edge.
module rcc_prescaler #(
    parameter int MAX_SHIFT = 16,
    parameter int SH_W      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            rise,
    input  logic [SH_W-1:0] shift,
    output logic            gate
);
    logic [MAX_SHIFT-1:0] cnt_q, cnt_d, term;

    always_comb begin
        term = ~({MAX_SHIFT{1'b1}} << shift);
        gate = run && rise && (cnt_q == term);
        cnt_d = cnt_q;
        if (!run)       cnt_d = '0;
        else if (gate)  cnt_d = '0;
        else if (rise)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rcc_timebase.sv
// Reference timer with capture on gate; span is the tick count of the closing gate.
module rcc_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_mode,
    input  logic             gate,
    output logic [CNT_W-1:0] span
);
    typedef struct packed {
        logic [CNT_W-1:0] timer;
        logic [CNT_W-1:0] mark;
    } tb_regs_t;

    tb_regs_t q, d;

    always_comb begin
        d = q;
        // Modulo subtraction: wrap between captures cancels out.
        span = clr_mode ? q.timer : (q.timer - q.mark);
        if (gate && clr_mode) d.timer = CNT_W'(1);
        else                  d.timer = q.timer + 1'b1;
        if (gate) d.mark = q.timer;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter
    import rcc_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int MAX_SHIFT = 16,
    parameter int SYNC_STG  = 2,
    localparam int SH_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             en,
    input  logic             auto_mode,
    input  logic [SH_W-1:0]  div_sel,
    input  logic             clr_mode,
    input  logic [CNT_W-1:0] min_ticks,
    input  logic             res_ack,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_cycles,
    output logic [CNT_W-1:0] res_ticks,
    output logic             overrun
);
    localparam logic [SH_W-1:0] SH_MAX = SH_W'(MAX_SHIFT);

    typedef struct packed {
        rcc_state_e       st;
        logic [SH_W-1:0]  shift;
        logic             clr_m;
        logic             armed;
        logic             valid;
        logic [CNT_W-1:0] cycles;
        logic [CNT_W-1:0] ticks;
        logic             pending;
        logic             ovr;
    } ctl_regs_t;

    ctl_regs_t q, d;

    logic             rise;
    logic             gate;
    logic [CNT_W-1:0] span;

    rcc_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sig_in),
        .rise     (rise)
    );

    rcc_prescaler #(.MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .rise  (rise),
        .shift (q.shift),
        .gate  (gate)
    );

    rcc_timebase #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mode (q.clr_m),
        .gate     (gate),
        .span     (span)
    );

    always_comb begin
        d = q;
        d.valid = 1'b0;
        if (res_ack) begin
            d.pending = 1'b0;
            d.ovr     = 1'b0;
        end
        unique case (q.st)
            ST_IDLE: begin
                d.armed = 1'b0;
                if (en) begin
                    d.clr_m = clr_mode;
                    if (auto_mode) begin
                        d.st    = ST_RANGE;
                        d.shift = '0;
                    end else begin
                        d.st    = ST_MEAS;
                        d.shift = (div_sel > SH_MAX) ? SH_MAX : div_sel;
                    end
                end
            end
            ST_RANGE: begin
                if (!en) begin
                    d.st = ST_IDLE;
                end else if (gate) begin
                    if (!q.armed) begin
                        d.armed = 1'b1;
                    end else if ((span <= min_ticks) && (q.shift < SH_MAX)) begin
                        d.shift = q.shift + 1'b1;
                    end else begin
                        // This edge opens the first reported gate.
                        d.st = ST_MEAS;
                    end
                end
            end
            ST_MEAS: begin
                if (!en) begin
                    d.st = ST_IDLE;
                end else if (gate) begin
                    d.armed = 1'b1;
                    if (q.armed) begin
                        d.valid   = 1'b1;
                        d.cycles  = CNT_W'(1) << q.shift;
                        d.ticks   = span;
                        d.pending = 1'b1;
                        if (q.pending && !res_ack) d.ovr = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign res_valid  = q.valid;
    assign res_cycles = q.cycles;
    assign res_ticks  = q.ticks;
    assign overrun    = q.ovr;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             res_ack,
    input logic             res_valid,
    input logic [CNT_W-1:0] res_cycles,
    input logic [CNT_W-1:0] res_ticks,
    input logic             overrun
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R9

    AST_CYCLES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_cycles) == 1)); // R2

    AST_TICKS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_ticks != '0)); // R3

    AST_OVR_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> res_valid); // R10

    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        res_ack |=> !overrun); // R10

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !res_valid); // R12
endmodule

bind recip_freq_counter rcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .res_ack    (res_ack),
    .res_valid  (res_valid),
    .res_cycles (res_cycles),
    .res_ticks  (res_ticks),
    .overrun    (overrun)
);

// File: tb/sim_recip_freq_counter.sv
`timescale 1ns/1ps
module sim_recip_freq_counter;
    localparam int CW   = 12;
    localparam int MAXS = 6;
    localparam int SW   = $clog2(MAXS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          en = 1'b0;
    logic          auto_mode = 1'b0;
    logic [SW-1:0] div_sel = '0;
    logic          clr_mode = 1'b0;
    logic [CW-1:0] min_ticks = '0;
    logic          res_ack = 1'b0;
    logic          res_valid;
    logic [CW-1:0] res_cycles;
    logic [CW-1:0] res_ticks;
    logic          overrun;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int pa = 8;
    int pb = 8;
    bit gen_on = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    recip_freq_counter #(.CNT_W(CW), .MAX_SHIFT(MAXS)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .en(en),
        .auto_mode(auto_mode), .div_sel(div_sel), .clr_mode(clr_mode),
        .min_ticks(min_ticks), .res_ack(res_ack), .res_valid(res_valid),
        .res_cycles(res_cycles), .res_ticks(res_ticks), .overrun(overrun)
    );

    // Input pattern: rising edges spaced pa then pb reference cycles.
    always begin
        if (gen_on) begin
            sig_in = 1'b1; repeat (pa / 2) @(negedge clk);
            sig_in = 1'b0; repeat (pa - pa / 2) @(negedge clk);
            sig_in = 1'b1; repeat (pb / 2) @(negedge clk);
            sig_in = 1'b0; repeat (pb - pb / 2) @(negedge clk);
        end else begin
            @(negedge clk);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic get_res(input bit do_ack, output int c, output int t);
        bit got = 1'b0;
        c = 0; t = 0;
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            if (res_valid) begin
                got = 1'b1;
                c = int'(res_cycles);
                t = int'(res_ticks);
            end
        end
        chk(got, "R3", "result arrived", longint'(got), 1);
        if (do_ack) begin
            res_ack = 1'b1;
            @(negedge clk);
            res_ack = 1'b0;
            chk(!res_valid, "R9", "strobe one cycle", longint'(res_valid), 0);
        end
    endtask

    task automatic start(input bit am, input int sel, input bit cm, input int mt,
                         input int p1, input int p2);
        @(negedge clk);
        pa = p1; pb = p2;
        auto_mode = am; div_sel = SW'(sel); clr_mode = cm; min_ticks = CW'(mt);
        gen_on = 1'b1;
        en = 1'b1;
    endtask

    task automatic stop();
        @(negedge clk);
        en = 1'b0;
        gen_on = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(res_valid == 0, "R1", "valid after reset", longint'(res_valid), 0);
        chk(overrun == 0, "R1", "overrun after reset", longint'(overrun), 0);
        chk(res_cycles == 0, "R1", "cycles after reset", longint'(res_cycles), 0);
        chk(res_ticks == 0, "R1", "ticks after reset", longint'(res_ticks), 0);
    endtask

    task automatic t_manual(input int sh, input int per, input int n);
        int c, t;
        start(0, sh, 0, 0, per, per);
        for (int i = 0; i < n; i++) begin
            get_res(1, c, t);
            chk(c == (1 << sh), "R2", "manual cycles", c, 1 << sh);
            chk(t == per * (1 << sh), "R3", "manual ticks", t, per * (1 << sh));
        end
        stop();
    endtask

    task automatic t_manual_clamp();
        int c, t;
        start(0, 7, 0, 0, 4, 4);
        get_res(1, c, t);
        chk(c == 64, "R2", "clamped manual cycles", c, 64);
        chk(t == 256, "R2", "clamped manual ticks", t, 256);
        stop();
    endtask

    task automatic t_gapless();
        int c, t, prev;
        start(0, 0, 0, 0, 6, 10);
        get_res(1, c, prev);
        for (int i = 0; i < 5; i++) begin
            get_res(1, c, t);
            chk(prev + t == 16, "R4", "pair sum", prev + t, 16);
            chk(t != prev, "R4", "periods alternate", t, 16 - prev);
            prev = t;
        end
        stop();
        start(0, 1, 0, 0, 6, 10);
        for (int i = 0; i < 3; i++) begin
            get_res(1, c, t);
            chk(t == 16, "R4", "two-cycle gate", t, 16);
        end
        stop();
    endtask

    task automatic t_wrap();
        int c, t;
        bit bad = 1'b0;
        int badv = 0;
        start(0, 3, 0, 0, 12, 12);
        for (int i = 0; i < 50; i++) begin
            get_res(1, c, t);
            if (t != 96 && !bad) begin bad = 1'b1; badv = t; end
        end
        chk(!bad, "R5", "ticks across timer wrap", bad ? badv : 96, 96);
        stop();
    endtask

    task automatic t_clear();
        int c, t;
        start(0, 2, 1, 0, 7, 7);
        get_res(1, c, t);
        chk(t == 28, "R6", "clear mode ticks", t, 28);
        @(negedge clk);
        div_sel = SW'(5); clr_mode = 1'b0; auto_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            get_res(1, c, t);
            chk(c == 4, "R11", "cycles after mode inputs change", c, 4);
            chk(t == 28, "R11", "ticks after mode inputs change", t, 28);
        end
        stop();
    endtask

    task automatic t_auto();
        int c, t;
        start(1, 0, 0, 35, 10, 10);
        get_res(1, c, t);
        chk(c == 4, "R7", "auto-range first cycles", c, 4);
        chk(t == 40, "R7", "auto-range first ticks", t, 40);
        get_res(1, c, t);
        chk(c == 4 && t == 40, "R7", "auto-range steady ticks", t, 40);
        stop();
    endtask

    task automatic t_auto_clamp();
        int c, t;
        start(1, 0, 0, 4000, 4, 4);
        get_res(1, c, t);
        chk(c == 64, "R8", "clamped auto cycles", c, 64);
        chk(t == 256, "R8", "clamped auto ticks", t, 256);
        stop();
    endtask

    task automatic t_overrun();
        int c, t;
        start(0, 0, 0, 0, 8, 8);
        get_res(0, c, t);
        chk(overrun == 0, "R10", "no overrun on first", longint'(overrun), 0);
        get_res(0, c, t);
        chk(overrun == 1, "R10", "overrun on unread result", longint'(overrun), 1);
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(overrun == 0, "R10", "overrun cleared by ack", longint'(overrun), 0);
        get_res(1, c, t);
        chk(overrun == 0, "R10", "no overrun after ack", longint'(overrun), 0);
        stop();
    endtask

    task automatic t_disabled();
        int c, t;
        int seen = 0;
        @(negedge clk);
        pa = 4; pb = 4; gen_on = 1'b1; en = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
        chk(seen == 0, "R12", "no results while disabled", seen, 0);
        gen_on = 1'b0;
        repeat (20) @(negedge clk);
        start(0, 2, 0, 0, 9, 9);
        get_res(1, c, t);
        chk(t == 36, "R12", "re-armed after enable", t, 36);
        stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_manual(0, 8, 3);
        t_manual(2, 6, 3);
        t_manual_clamp();
        t_gapless();
        t_wrap();
        t_clear();
        t_auto();
        t_auto_clamp();
        t_overrun();
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule